// File: doc/BRIEF.md
# Ethernet Receive Frame Classifier

This block watches a received Ethernet frame as it passes on a 128-bit packet stream and, once the frame has ended, reports a 40-bit summary of it. The summary tells the consumer how the destination address is addressed (single station, group or all stations), whether the frame carries one or two VLAN tags, and whether it is a MAC control frame. For MAC control frames it also says whether the frame is a pause request or a per-priority pause request. Two 16-bit lengths complete the summary: the whole frame and its payload.

Frames arrive as beats with start, end and empty markers. Within a beat the earliest byte of the frame sits in the top lane, `in_data[127:120]`. The stream carries the FCS, so the last valid byte of the end beat is the last FCS byte. The block never holds the stream back: `in_ready` is always high, and a beat is taken on every cycle where `in_valid` is high. The summary appears on plain status pins, `stat_data` and `stat_valid`, with no handshake. The consumer must capture it in the cycle `stat_valid` is high. Filtering, flow-control actions and error detection are done elsewhere.

Top module: `rx_frame_classifier`

## Requirements
- R1: The address flags are exactly one-hot across `stat_data[38]` (single station), `stat_data[37]` (group) and `stat_data[36]` (all stations). The all-stations flag is set when all 48 destination bits are one. The group flag is set when bit 0 of the first destination byte is one and the address is not all ones. Otherwise the single-station flag is set.
- R2: When the EtherType that follows any VLAN tags equals 0x8808, the control flag `stat_data[34]` is set. Any other EtherType leaves it clear.
- R3: For a control frame, the two bytes after the EtherType form an opcode. Opcode 0x0001 also sets the pause flag `stat_data[35]`, and opcode 0x0101 also sets the priority-pause flag `stat_data[39]`. Any other opcode, or the same values on a frame that is not a control frame, sets neither flag.
- R4: An outer tag identifier (bytes 12 and 13) of 0x8100 sets the VLAN flag `stat_data[33]`. The parse then reads the next type field 4 bytes later.
- R5: An outer tag identifier of 0x88A8 sets the stacked flag `stat_data[32]`. So does an outer tag of 0x8100 or 0x88A8 that is followed by a second tag identifier of either value at bytes 16 and 17. With two tags, the EtherType and opcode are read 8 bytes later than in an untagged frame.
- R6: `stat_data[31:16]` holds the frame length in bytes, from the first destination byte through the last FCS byte. A non-end beat carries 16 bytes. The end beat carries 16 minus `in_empty` bytes, and the unused bytes are the low-order lanes.
- R7: `stat_data[15:0]` holds the payload length. It is the frame length minus the header (14 bytes plus 4 per tag) minus the 4-byte FCS, or 0 when that difference would be zero or negative.
- R8: `stat_valid` is high for exactly one cycle, the cycle after each accepted end beat, including end beats on consecutive cycles. Between these pulses, `stat_data` holds its last value.
- R9: Byte n of the frame is taken from beat n/16, lane n%16, where lane 0 is `in_data[127:120]`. Header bytes that a short frame never supplies read as zero.
- R10: A start beat discards any unfinished frame. The classification and the lengths then cover only the frame opened by the newest start beat.
- R11: `in_ready` is always 1. A cycle with `in_valid` low changes neither output, whatever the other inputs carry.
- R12: During reset, `stat_valid` is 0 and `stat_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat present on the stream |
| in_ready | output | 1 | Always 1; the block never stalls the stream |
| in_sop | input | 1 | Beat holds the first frame byte |
| in_eop | input | 1 | Beat holds the last frame byte (last FCS byte) |
| in_empty | input | 4 | Unused low-order lanes on the end beat |
| in_data | input | 128 | Frame bytes, earliest byte in the top lane |
| stat_valid | output | 1 | One-cycle strobe qualifying stat_data |
| stat_data | output | 40 | Type flags [39:32], frame length [31:16], payload length [15:0] |

## Verification
The bench builds the block with its default 128-bit width, so a beat holds 16 bytes. A doubly tagged header is 24 bytes, which puts its EtherType and opcode in the second beat. This brings two things within reach: merging a second-beat header byte in the same cycle as the end beat, and clearing header bytes that a 10-byte frame never delivers. A 1518-byte frame drives the header-beat counter into saturation, and frames of 18 and 19 bytes test the zero limit on the payload length. Single-beat frames on consecutive cycles show that the strobe has no dead cycle.

// File: rtl/rx_cls_pkg.sv
package rx_cls_pkg;
  localparam int LEN_W     = 16;
  localparam int FLAG_W    = 8;
  localparam int STAT_W    = FLAG_W + 2 * LEN_W;
  localparam int MAX_TAGS  = 2;
  localparam int BASE_HDR  = 14;
  localparam int TAG_BYTES = 4;
  localparam int FCS_BYTES = 4;
  localparam int HDR_BYTES = BASE_HDR + TAG_BYTES * MAX_TAGS + 2;

  localparam logic [15:0] TPID_CUST  = 16'h8100;
  localparam logic [15:0] TPID_SVC   = 16'h88A8;
  localparam logic [15:0] ETYPE_CTL  = 16'h8808;
  localparam logic [15:0] OPC_PAUSE  = 16'h0001;
  localparam logic [15:0] OPC_PRIO   = 16'h0101;

  typedef struct packed {
    logic              prio_pause;
    logic              ucast;
    logic              mcast;
    logic              bcast;
    logic              pause;
    logic              ctrl;
    logic              vlan;
    logic              svlan;
    logic [LEN_W-1:0]  frame_len;
    logic [LEN_W-1:0]  pay_len;
  } rx_stat_t;
endpackage

// File: rtl/rx_cls_hdr_capture.sv
module rx_cls_hdr_capture
  import rx_cls_pkg::*;
#(
  parameter int BYTES = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        beat,
  input  logic                        sop,
  input  logic                        eop,
  input  logic [BYTES*8-1:0]          data,
  output logic [HDR_BYTES-1:0][7:0]   hdr_now
);
  localparam int HDR_BEATS = (HDR_BYTES + BYTES - 1) / BYTES;
  localparam int BEAT_W    = $clog2(HDR_BEATS + 1);

  logic [HDR_BYTES-1:0][7:0] hdr_q;
  logic [BEAT_W-1:0]         idx_q;
  logic [BEAT_W-1:0]         base_idx;

  assign base_idx = sop ? '0 : idx_q;

  // Each header byte takes its lane when the current beat covers it,
  // is cleared on a start beat otherwise, and holds in all other cycles.
  for (genvar i = 0; i < HDR_BYTES; i++) begin : g_byte
    localparam int BN = i / BYTES;
    localparam int LN = i % BYTES;
    assign hdr_now[i] = (beat && (base_idx == BEAT_W'(BN))) ? data[BYTES*8-1-8*LN -: 8] :
                        (beat && sop)                       ? 8'h00 :
                                                              hdr_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_q <= '0;
      idx_q <= '0;
    end else begin
      hdr_q <= hdr_now;
      if (beat) begin
        if (eop)
          idx_q <= '0;
        else if (base_idx == BEAT_W'(HDR_BEATS))
          idx_q <= base_idx;
        else
          idx_q <= base_idx + 1'b1;
      end
    end
  end

  // R9
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= BEAT_W'(HDR_BEATS));

  // R10
  sop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sop && !eop) |=> (idx_q == BEAT_W'(1)));
endmodule

// File: rtl/rx_cls_len_count.sv
module rx_cls_len_count
  import rx_cls_pkg::*;
#(
  parameter int BYTES   = 16,
  parameter int EMPTY_W = $clog2(BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat,
  input  logic               sop,
  input  logic               eop,
  input  logic [EMPTY_W-1:0] empty,
  output logic [LEN_W-1:0]   len_now
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] add;

  assign add     = eop ? (LEN_W'(BYTES) - LEN_W'(empty)) : LEN_W'(BYTES);
  assign len_now = (sop ? '0 : cnt_q) + add;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (beat)
      cnt_q <= eop ? '0 : len_now;
  end

  // R6
  mid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !eop) |=> (cnt_q == $past(sop ? LEN_W'(BYTES) : cnt_q + LEN_W'(BYTES))));
endmodule

// File: rtl/rx_cls_decode.sv
module rx_cls_decode
  import rx_cls_pkg::*;
(
  input  logic [HDR_BYTES-1:0][7:0] hdr,
  input  logic [LEN_W-1:0]          frame_len,
  output rx_stat_t                  stat
);
  logic [15:0]      tpid_out, tpid_in, etype, opcode;
  logic             tag1, tag2;
  logic [LEN_W-1:0] overhead;
  logic             unused_src;

  assign unused_src = ^{hdr[6], hdr[7], hdr[8], hdr[9], hdr[10], hdr[11]};

  assign tpid_out = {hdr[12], hdr[13]};
  assign tpid_in  = {hdr[16], hdr[17]};
  assign tag1     = (tpid_out == TPID_CUST) || (tpid_out == TPID_SVC);
  assign tag2     = tag1 && ((tpid_in == TPID_CUST) || (tpid_in == TPID_SVC));

  always_comb begin
    if (tag2) begin
      etype    = {hdr[20], hdr[21]};
      opcode   = {hdr[22], hdr[23]};
      overhead = LEN_W'(BASE_HDR + 2 * TAG_BYTES + FCS_BYTES);
    end else if (tag1) begin
      etype    = {hdr[16], hdr[17]};
      opcode   = {hdr[18], hdr[19]};
      overhead = LEN_W'(BASE_HDR + TAG_BYTES + FCS_BYTES);
    end else begin
      etype    = {hdr[12], hdr[13]};
      opcode   = {hdr[14], hdr[15]};
      overhead = LEN_W'(BASE_HDR + FCS_BYTES);
    end
  end

  always_comb begin
    stat.bcast      = &{hdr[0], hdr[1], hdr[2], hdr[3], hdr[4], hdr[5]};
    stat.mcast      = hdr[0][0] && !stat.bcast;
    stat.ucast      = !hdr[0][0];
    stat.ctrl       = (etype == ETYPE_CTL);
    stat.pause      = stat.ctrl && (opcode == OPC_PAUSE);
    stat.prio_pause = stat.ctrl && (opcode == OPC_PRIO);
    stat.vlan       = (tpid_out == TPID_CUST);
    stat.svlan      = (tpid_out == TPID_SVC) || tag2;
    stat.frame_len  = frame_len;
    stat.pay_len    = (frame_len > overhead) ? (frame_len - overhead) : '0;
  end
endmodule

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
  import rx_cls_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic                          in_sop,
  input  logic                          in_eop,
  input  logic [$clog2(DATA_W/8)-1:0]   in_empty,
  input  logic [DATA_W-1:0]             in_data,
  output logic                          stat_valid,
  output logic [STAT_W-1:0]             stat_data
);
  localparam int BYTES   = DATA_W / 8;
  localparam int EMPTY_W = $clog2(BYTES);

  logic                      acc;
  logic [HDR_BYTES-1:0][7:0] hdr_now;
  logic [LEN_W-1:0]          len_now;
  rx_stat_t                  stat_now;
  rx_stat_t                  stat_q;
  logic                      valid_q;

  assign in_ready = 1'b1;
  assign acc      = in_valid && in_ready;

  rx_cls_hdr_capture #(.BYTES(BYTES)) u_hdr (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (acc),
    .sop     (in_sop),
    .eop     (in_eop),
    .data    (in_data),
    .hdr_now (hdr_now)
  );

  rx_cls_len_count #(.BYTES(BYTES), .EMPTY_W(EMPTY_W)) u_len (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (acc),
    .sop     (in_sop),
    .eop     (in_eop),
    .empty   (in_empty),
    .len_now (len_now)
  );

  rx_cls_decode u_dec (
    .hdr       (hdr_now),
    .frame_len (len_now),
    .stat      (stat_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      stat_q  <= '0;
    end else begin
      valid_q <= acc && in_eop;
      if (acc && in_eop)
        stat_q <= stat_now;
    end
  end

  assign stat_valid = valid_q;
  assign stat_data  = stat_q;

  // R8
  pulse_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_eop) |=> stat_valid);

  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && in_eop) |=> !stat_valid);

  // R8
  hold_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && in_eop) |=> $stable(stat_data));

  // R1
  addr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> ($countones({stat_q.ucast, stat_q.mcast, stat_q.bcast}) == 1));

  // R3
  ctl_subtype_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && (stat_q.pause || stat_q.prio_pause)) |->
      (stat_q.ctrl && $onehot0({stat_q.pause, stat_q.prio_pause})));

  // R7
  pay_within_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_q.pay_len < stat_q.frame_len || stat_q.pay_len == '0));
endmodule

// File: tb/rx_frame_classifier_bench.sv
module rx_frame_classifier_bench;
  typedef struct packed {
    logic [47:0] da;
    logic [95:0] w;
    logic [15:0] len;
    logic [7:0]  fl;
    logic [1:0]  tags;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{48'h001122334455, {16'h0800, 16'h0001, 64'h0}, 16'd64,   8'h40, 2'd0},
    '{48'hFFFFFFFFFFFF, {16'h0806, 80'h0},           16'd60,   8'h10, 2'd0},
    '{48'h01005E000001, {16'h0800, 80'h0},           16'd100,  8'h20, 2'd0},
    '{48'h0180C2000001, {16'h8808, 16'h0001, 64'h0}, 16'd64,   8'h2C, 2'd0},
    '{48'h0180C2000001, {16'h8808, 16'h0101, 64'h0}, 16'd64,   8'hA4, 2'd0},
    '{48'h020000000001, {16'h8808, 16'h0002, 64'h0}, 16'd64,   8'h44, 2'd0},
    '{48'h001122334455, {16'h8100, 16'h0005, 16'h0800, 48'h0}, 16'd68, 8'h42, 2'd1},
    '{48'h001122334455, {16'h8100, 16'h0000, 16'h8808, 16'h0001, 32'h0}, 16'd68, 8'h4E, 2'd1},
    '{48'h001122334455, {16'h88A8, 16'h0007, 16'h0800, 48'h0}, 16'd80, 8'h41, 2'd1},
    '{48'hFFFFFFFFFFFF, {16'h8100, 16'h0003, 16'h8100, 16'h0004, 16'h8808, 16'h0101}, 16'd72, 8'h97, 2'd2},
    '{48'h01005E7F0001, {16'h88A8, 16'h0001, 16'h8100, 16'h0002, 16'h0800, 16'h0}, 16'd1518, 8'h21, 2'd2},
    '{48'h001122334455, {16'h8808, 16'h0001, 64'h0}, 16'd10,   8'h40, 2'd0},
    '{48'h001122334455, {16'h0800, 80'h0},           16'd19,   8'h40, 2'd0},
    '{48'h001122334455, {16'h0800, 80'h0},           16'd18,   8'h40, 2'd0},
    '{48'hFFFFFFFFFFFE, {16'h0800, 80'h0},           16'd64,   8'h20, 2'd0}
  };
  localparam string FTAG [NV] = '{
    "R1", "R1", "R1", "R3", "R3", "R2", "R4", "R4",
    "R5", "R5", "R5", "R9", "R7", "R7", "R1"
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_sop = 1'b0;
  logic         in_eop = 1'b0;
  logic [3:0]   in_empty = '0;
  logic [127:0] in_data = '0;
  logic         stat_valid;
  logic [39:0]  stat_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  rx_frame_classifier u_rx_frame_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty), .in_data(in_data),
    .stat_valid(stat_valid), .stat_data(stat_data)
  );

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input vec_t v, input int i);
    if (i < 6)  return v.da[47-8*i -: 8];
    if (i < 12) return 8'(16 + i);
    if (i < 24) return v.w[95-8*(i-12) -: 8];
    return 8'(i * 7);
  endfunction

  function automatic logic [39:0] expect_of(input vec_t v);
    int ovh;
    logic [15:0] pay;
    ovh = 18 + 4 * int'(v.tags);
    pay = (int'(v.len) > ovh) ? 16'(int'(v.len) - ovh) : 16'd0;
    return {v.fl, v.len, pay};
  endfunction

  // drives beats of a frame; with stop_early only the first beat, no end
  task automatic drive_frame(input vec_t v, input bit stop_early);
    int nb;
    nb = (int'(v.len) + 15) / 16;
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (b == 0);
      in_eop   = (b == nb - 1) && !stop_early;
      in_empty = (b == nb - 1) ? 4'(nb * 16 - int'(v.len)) : 4'd0;
      for (int k = 0; k < 16; k++)
        in_data[127-8*k -: 8] = (b * 16 + k < int'(v.len)) ? byte_at(v, b * 16 + k) : 8'h00;
      if (stop_early) break;
    end
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_empty = '0; in_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [39:0] exp, held;
    // R12 reset state, R11 ready
    repeat (3) @(negedge clk);
    check("R12 valid in reset", {39'd0, stat_valid}, 40'd0);
    check("R12 data in reset", stat_data, 40'd0);
    check("R11 ready", {39'd0, in_ready}, 40'd1);
    rst_n = 1'b1;

    // table walk
    for (int n = 0; n < NV; n++) begin
      drive_frame(VEC[n], 1'b0);
      @(negedge clk);
      idle_inputs();
      exp = expect_of(VEC[n]);
      check("R8 strobe", {39'd0, stat_valid}, 40'd1);
      check($sformatf("R1/R9 addr flags vec %0d", n), {37'd0, stat_data[38:36]}, {37'd0, exp[38:36]});
      check($sformatf("%s type flags vec %0d", FTAG[n], n), {35'd0, stat_data[39], stat_data[35:32]},
            {35'd0, exp[39], exp[35:32]});
      check($sformatf("R6 frame length vec %0d", n), {24'd0, stat_data[31:16]}, {24'd0, exp[31:16]});
      check($sformatf("R7 payload length vec %0d", n), {24'd0, stat_data[15:0]}, {24'd0, exp[15:0]});
      @(negedge clk);
      check("R8 single pulse", {39'd0, stat_valid}, 40'd0);
      check("R8 hold", stat_data, exp);
    end

    // R11: invalid cycles with noisy controls change nothing
    held = stat_data;
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b1; in_eop = 1'b1; in_data = {128{1'b1}};
    repeat (3) begin
      @(negedge clk);
      check("R11 idle valid", {39'd0, stat_valid}, 40'd0);
      check("R11 idle data", stat_data, held);
    end
    idle_inputs();

    // R10: abandoned frame then a full frame
    drive_frame(VEC[9], 1'b1);
    drive_frame(VEC[0], 1'b0);
    @(negedge clk);
    idle_inputs();
    check("R10 restart strobe", {39'd0, stat_valid}, 40'd1);
    check("R10 restart status", stat_data, expect_of(VEC[0]));

    // R8: single-beat frames on consecutive cycles
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_empty = 4'd0;
    in_data = {48'hFFFFFFFFFFFF, 80'h0};
    @(negedge clk);
    in_data = {48'h001122334455, 80'h0};
    check("R8 back-to-back first", {stat_valid, stat_data},
          {1'b1, 8'h10, 16'd16, 16'd0});
    @(negedge clk);
    idle_inputs();
    check("R8 back-to-back second", {stat_valid, stat_data},
          {1'b1, 8'h40, 16'd16, 16'd0});
    @(negedge clk);
    check("R8 back-to-back end", {39'd0, stat_valid}, 40'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule